// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block models the control logic of a static RAM that carries a nonvolatile shadow copy of its contents. A host reaches the working array over a chip-select style bus (active-low chip enable, write enable and output enable, an address bus and a data bus), with every bus pin sampled on the system clock. The shadow copy is never accessed directly. A STORE copies the whole working array into the shadow, and a RECALL copies the shadow back into the working array.

Software starts either operation by hiding a key inside ordinary reads. Six consecutive chip-enable read cycles must present a fixed run of five addresses, and the sixth address then selects STORE or RECALL. Each of these reads still returns data as usual. A separate active-low hardware store request performs a STORE only when the working array has been written since the last nonvolatile operation. In both cases the block then stays locked until the request is withdrawn. While an operation runs, the bus is inert and a busy flag is raised for a parameterised number of cycles.

The working array has 2^MEM_AW words and is indexed by the low MEM_AW address bits, so higher addresses alias. The key is always decoded on the full 13-bit address.

Top module: `nvsram_ctl`

## Requirements
- R1: With `ce_n` high, `dout_oe` is low whatever `we_n` and `oe_n` are.
- R2: With `ce_n` low, `we_n` high, `oe_n` low and the block idle, `dout_oe` is high and `dout` equals the word at index `addr[MEM_AW-1:0]`.
- R3: With `ce_n` and `we_n` low and the block idle, the word at index `addr[MEM_AW-1:0]` takes `din` on the clock edge.
- R4: Six falling edges of `ce_n` with `we_n` high at addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F start a STORE. Once the STORE completes, the shadow holds the working array as it stood when the STORE began.
- R5: The same five addresses followed by 0x0F0E start a RECALL. When the RECALL ends, the working array equals the shadow.
- R6: Any write, or any out-of-order address, aborts a partial key. An out-of-order address of 0x0000 counts as a fresh first step of the key.
- R7: Key reads return stored data like any other read, and the key is recognised whether `oe_n` is high or low.
- R8: `busy` is high for exactly BUSY_CYC cycles after a software STORE or RECALL starts. During that time reads leave `dout_oe` low and writes change nothing.
- R9: When `hsb_n` falls after at least one write, a STORE of BUSY_CYC cycles runs. The block then stays busy and ignores the bus until `hsb_n` is high again, and leaves busy one cycle after that.
- R10: When `hsb_n` falls with no write since the last nonvolatile operation, no STORE runs and the block is only locked. A one-cycle low pulse on `hsb_n` gives exactly one busy cycle.
- R11: When a STORE or RECALL completes, the "written" condition is cleared, so a following hardware request is skipped until another write occurs.
- R12: After reset, `busy` is low, the working array reads all zeros, and shadow word i holds SHADOW_SEED XOR i (truncated to DW bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hsb_n | input | 1 | Hardware store request, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dout_oe | output | 1 | High when `dout` should drive the bus |
| busy | output | 1 | Nonvolatile operation or hardware lock in progress |

## Verification
The bench writes distinct arithmetic patterns over every word of the array, and each pattern marks which of several copies a later read returns: reset zeros, the seed pattern, or a stored snapshot. A STORE is proved by overwriting the array and then recalling. The key is tried in these forms: complete with the output enable low and high, broken by a write, broken by a stray address, and restarted by a repeated 0x0000. Each form either starts an operation or does not, and the measured busy length tells them apart. Hardware requests are tried with clean and dirty arrays, with pulsed and held releases. In these cases the busy length (1, BUSY_CYC+1 or held) shows whether a STORE ran.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int KEY_AW = 13;

  localparam logic [KEY_AW-1:0] KEY_STORE  = 13'h0F0F;
  localparam logic [KEY_AW-1:0] KEY_RECALL = 13'h0F0E;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_STORE,
    OP_RECALL
  } nv_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STORE,
    S_RECALL,
    S_HSB_ST,
    S_LOCK
  } nv_state_e;

  // Expected address for key positions 0..4; position 5 selects the operation.
  function automatic logic [KEY_AW-1:0] key_at(input logic [2:0] pos);
    case (pos)
      3'd0:    key_at = 13'h0000;
      3'd1:    key_at = 13'h1555;
      3'd2:    key_at = 13'h0AAA;
      3'd3:    key_at = 13'h1FFF;
      3'd4:    key_at = 13'h10F0;
      default: key_at = 13'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nvs_key_match.sv
module nvs_key_match
  import nvs_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ce_fall,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output nv_op_e        op_req
);

  localparam logic [2:0] LAST_POS = 3'd5;

  logic [2:0] pos_q, pos_d;
  nv_op_e     op_d;

  always_comb begin
    pos_d = pos_q;
    op_d  = OP_NONE;
    if (!en || wr) begin
      pos_d = '0;
    end else if (ce_fall) begin
      if (pos_q == LAST_POS) begin
        if (addr == AW'(KEY_STORE)) begin
          op_d  = OP_STORE;
          pos_d = '0;
        end else if (addr == AW'(KEY_RECALL)) begin
          op_d  = OP_RECALL;
          pos_d = '0;
        end else if (addr == AW'(key_at(3'd0))) begin
          pos_d = 3'd1;
        end else begin
          pos_d = '0;
        end
      end else if (addr == AW'(key_at(pos_q))) begin
        pos_d = pos_q + 3'd1;
      end else if (addr == AW'(key_at(3'd0))) begin
        pos_d = 3'd1;
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign op_req = op_d;

  assert_write_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pos_q == 3'd0));

  assert_fire_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d != OP_NONE) |=> (pos_q == 3'd0));

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int BUSY_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hsb_n,
  input  nv_op_e op_req,
  input  logic   wr_fire,
  output logic   busy,
  output logic   do_store,
  output logic   do_recall
);

  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC - 1);

  nv_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dirty_q, dirty_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    do_store  = 1'b0;
    do_recall = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (!hsb_n) begin
          state_d = dirty_q ? S_HSB_ST : S_LOCK;
          cnt_d   = LOAD;
        end else if (op_req == OP_STORE) begin
          state_d = S_STORE;
          cnt_d   = LOAD;
        end else if (op_req == OP_RECALL) begin
          state_d = S_RECALL;
          cnt_d   = LOAD;
        end
      end
      S_STORE, S_HSB_ST: begin
        if (cnt_zero) begin
          do_store = 1'b1;
          state_d  = (state_q == S_HSB_ST) ? S_LOCK : S_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_RECALL: begin
        if (cnt_zero) begin
          do_recall = 1'b1;
          state_d   = S_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_LOCK: begin
        if (hsb_n) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    dirty_d = dirty_q;
    if (do_store || do_recall) dirty_d = 1'b0;
    else if (wr_fire)          dirty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dirty_q <= dirty_d;
    end
  end

  assign busy = (state_q != S_IDLE);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOCK && !hsb_n) |=> (state_q == S_LOCK));

  assert_skip_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !hsb_n && !dirty_q) |=> (state_q == S_LOCK && !do_store));

  assert_dirty_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (do_store || do_recall) |=> !dirty_q);

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int              MEM_AW      = 6,
  parameter int              DW          = 8,
  parameter logic [DW-1:0]   SHADOW_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  input  logic              do_store,
  input  logic              do_recall,
  output logic [DW-1:0]     rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] sram_q [DEPTH];
  logic [DW-1:0] nv_q   [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
    end else if (do_recall) begin
      sram_q <= nv_q;
    end else if (wr_en) begin
      sram_q[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) nv_q[i] <= SHADOW_SEED ^ DW'(i);
    end else if (do_store) begin
      nv_q <= sram_q;
    end
  end

  assign rdata = sram_q[idx];

endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
  import nvs_pkg::*;
#(
  parameter int            AW          = 13,
  parameter int            MEM_AW      = 6,
  parameter int            DW          = 8,
  parameter int            BUSY_CYC    = 16,
  parameter logic [DW-1:0] SHADOW_SEED = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          hsb_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          busy
);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          ce_q;
  logic          ce_fall;
  logic          wr_raw;
  logic          wr_fire;
  logic          rd_en;
  nv_op_e        op_req;
  logic          do_store, do_recall;
  logic [DW-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ce_q <= 1'b1;
    else          ce_q <= ce_n;
  end

  assign ce_fall = ce_q & ~ce_n;
  assign wr_raw  = ~ce_n & ~we_n;
  assign wr_fire = wr_raw & ~busy;
  assign rd_en   = ~ce_n & we_n & ~oe_n & ~busy;

  nvs_key_match #(.AW(AW)) key_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (~busy),
    .ce_fall (ce_fall),
    .wr      (wr_raw),
    .addr    (addr),
    .op_req  (op_req)
  );

  nvs_seq #(.BUSY_CYC(BUSY_CYC)) seq_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .hsb_n     (hsb_n),
    .op_req    (op_req),
    .wr_fire   (wr_fire),
    .busy      (busy),
    .do_store  (do_store),
    .do_recall (do_recall)
  );

  nvs_array #(.MEM_AW(MEM_AW), .DW(DW), .SHADOW_SEED(SHADOW_SEED)) mem_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_fire),
    .idx       (addr[MEM_AW-1:0]),
    .wdata     (din),
    .do_store  (do_store),
    .do_recall (do_recall),
    .rdata     (rdata)
  );

  assign dout    = rd_en ? rdata : '0;
  assign dout_oe = rd_en;

  assert_op_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_req != OP_NONE && !busy && hsb_n) |=> busy);

  assert_busy_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(busy) && busy) |-> !dout_oe);

endmodule

// File: tb/nvsram_ctl_tb_top.sv
module nvsram_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int MEM_AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int BUSY_CYC = 16;
  localparam int SEED = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, hsb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe, busy;

  int errors = 0;
  int checks = 0;
  int exp_sram [DEPTH];
  int exp_nv   [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_ctl #(.AW(AW), .MEM_AW(MEM_AW), .DW(DW), .BUSY_CYC(BUSY_CYC),
               .SHADOW_SEED(8'(SEED))) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .hsb_n(hsb_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int key_addr(input int p);
    case (p)
      0: return 'h0000;
      1: return 'h1555;
      2: return 'h0AAA;
      3: return 'h1FFF;
      default: return 'h10F0;
    endcase
  endfunction

  // One read cycle; optionally compares data against the model.
  task automatic bus_read(input int a, input bit cmp, input string req);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    #1;
    if (cmp) begin
      chk(dout_oe === 1'b1, req, int'(dout_oe), 1);
      chk(dout === DW'(exp_sram[a % DEPTH]), req, int'(dout), exp_sram[a % DEPTH]);
    end
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic bus_write(input int a, input int d, input bit upd);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = AW'(a); din = DW'(d);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    if (upd) exp_sram[a % DEPTH] = d & 'hFF;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_key(input int last, input bit cmp, input string req);
    for (int p = 0; p < 5; p++) bus_read(key_addr(p), cmp, req);
    bus_read(last, cmp, req);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < DEPTH; i++) bus_read(i, 1'b1, req);
  endtask

  task automatic hsb_pulse(output int n);
    @(negedge clk); hsb_n = 1'b0;
    @(negedge clk); hsb_n = 1'b1;
    count_busy(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) begin
      exp_sram[i] = 0;
      exp_nv[i]   = (SEED ^ i) & 'hFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    chk(busy === 1'b0, "R12 busy after reset", int'(busy), 0);
    read_all("R12 zero array / R2 read");

    // R1: deselected with oe low and we in either state
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #1;
    chk(dout_oe === 1'b0, "R1 deselect we high", int'(dout_oe), 0);
    we_n = 1'b0; #1;
    chk(dout_oe === 1'b0, "R1 deselect we low", int'(dout_oe), 0);
    we_n = 1'b1;

    // R3 / R2: writes through aliased addresses, read back at low index
    for (int i = 0; i < DEPTH; i++) bus_write(i | 'h0C00, i * 7 + 3, 1'b1);
    read_all("R3 write pattern");

    // R5 / R7: recall key with oe low, key reads return data
    run_key('h0F0E, 1'b1, "R7 key read data");
    count_busy(n);
    chk(n == BUSY_CYC, "R8 recall busy length", n, BUSY_CYC);
    for (int i = 0; i < DEPTH; i++) exp_sram[i] = exp_nv[i];
    read_all("R5 recall seed pattern");

    // R4 / R7 / R8: store key with oe high, bus attempts while busy
    for (int i = 0; i < DEPTH; i++) bus_write(i, ((~i) * 3) & 'hFF, 1'b1);
    oe_n = 1'b1;
    run_key('h0F0F, 1'b0, "R7");
    oe_n = 1'b0;
    chk(busy === 1'b1, "R7 store with oe high", int'(busy), 1);
    for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = 13'd5; #1;
    chk(dout_oe === 1'b0, "R8 read while busy", int'(dout_oe), 0);
    @(negedge clk); ce_n = 1'b1;
    bus_write(5, 'h3C, 1'b0);
    count_busy(n);
    chk(n + 4 == BUSY_CYC, "R8 store busy length", n + 4, BUSY_CYC);
    bus_read(5, 1'b1, "R8 write ignored while busy");
    for (int i = 0; i < DEPTH; i++) bus_write(i, i ^ 'h5A, 1'b1);
    run_key('h0F0E, 1'b0, "R4");
    count_busy(n);
    for (int i = 0; i < DEPTH; i++) exp_sram[i] = exp_nv[i];
    read_all("R4 stored snapshot recalled");

    // R6: write inside key aborts
    for (int p = 0; p < 3; p++) bus_read(key_addr(p), 1'b0, "R6");
    bus_write('h20, 'h11, 1'b1);
    bus_read(key_addr(3), 1'b0, "R6"); bus_read(key_addr(4), 1'b0, "R6");
    bus_read('h0F0F, 1'b0, "R6");
    chk(busy === 1'b0, "R6 write aborts key", int'(busy), 0);

    // R6: stray address aborts
    bus_read(key_addr(0), 1'b0, "R6"); bus_read(key_addr(1), 1'b0, "R6");
    bus_read('h0001, 1'b0, "R6");
    for (int p = 2; p < 5; p++) bus_read(key_addr(p), 1'b0, "R6");
    bus_read('h0F0E, 1'b0, "R6");
    chk(busy === 1'b0, "R6 stray address aborts key", int'(busy), 0);

    // R6: repeated 0x0000 restarts the key
    bus_read(key_addr(0), 1'b0, "R6"); bus_read(key_addr(1), 1'b0, "R6");
    run_key('h0F0E, 1'b0, "R6");
    count_busy(n);
    chk(n == BUSY_CYC, "R6 restart at 0x0000 recall", n, BUSY_CYC);
    for (int i = 0; i < DEPTH; i++) exp_sram[i] = exp_nv[i];
    bus_read('h20, 1'b1, "R6 recall after restart");

    // R10 / R11: clean after recall, hardware request skipped
    hsb_pulse(n);
    chk(n == 1, "R10 clean hsb busy length", n, 1);

    // R9: dirty hsb with early release
    for (int i = 0; i < DEPTH; i++) bus_write(i, (i * 11 + 1) & 'hFF, 1'b1);
    hsb_pulse(n);
    chk(n == BUSY_CYC + 1, "R9 dirty hsb busy length", n, BUSY_CYC + 1);
    for (int i = 0; i < DEPTH; i++) exp_nv[i] = exp_sram[i];

    // R11: store cleared the condition
    hsb_pulse(n);
    chk(n == 1, "R11 hsb after store skipped", n, 1);

    for (int i = 0; i < DEPTH; i++) bus_write(i, 'hF0 ^ i, 1'b1);
    run_key('h0F0E, 1'b0, "R9");
    count_busy(n);
    for (int i = 0; i < DEPTH; i++) exp_sram[i] = exp_nv[i];
    read_all("R9 hsb store snapshot");

    // R9: held request keeps lock and bus inert
    bus_write(3, 'h77, 1'b1);
    @(negedge clk); hsb_n = 1'b0;
    repeat (BUSY_CYC + 5) @(negedge clk);
    chk(busy === 1'b1, "R9 lock held", int'(busy), 1);
    ce_n = 1'b0; we_n = 1'b1; addr = 13'd9; #1;
    chk(dout_oe === 1'b0, "R9 read blocked in lock", int'(dout_oe), 0);
    @(negedge clk); ce_n = 1'b1;
    bus_write(9, 'h99, 1'b0);
    chk(busy === 1'b1, "R9 lock still held", int'(busy), 1);
    hsb_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R9 release after hsb high", int'(busy), 0);
    bus_read(9, 1'b1, "R9 write ignored in lock");
    bus_read(3, 1'b1, "R9 data kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule